// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits between a memory controller's command decoder and the column path of a synchronous DRAM. A mode-register-set command loads a configuration word: burst length, burst order, CAS latency and a single-access write option. After that, each read or write command starts a burst. For every beat of the burst the block puts out the column address and bank, and for write beats a write enable that the per-beat data mask has already gated.

On the read side the block produces the data-bus output enable. This enable follows the programmed CAS latency, and the mask input switches it off two cycles after the mask is sampled. A burst-stop command, or a precharge that hits the bank being read, ends the burst early. Read data already in flight still drains. A later read or write command replaces the running burst. After every mode-register-set the block also shows a short window in which a row activate is not yet allowed.

Commands are applied one per clock on `cmd_op`, together with `cmd_bank` and `cmd_addr`. `cmd_addr[8:0]` is the column, `cmd_addr[10]` is the all-banks flag and the whole word is the mode word.

Top module: `sdr_burst_seq`

## Requirements
- R1: A mode-register-set command (`cmd_op`=1) loads a legal mode word. Bits [2:0] set the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page. Bit 3 selects the order: 0 sequential, 1 interleaved. Bits [6:4] set the CAS latency: 010=2, 011=3. Bit 9 = 1 selects single-access writes. Bits [8:7] must be 00.
- R2: A mode word with a reserved code raises `mode_err` for exactly the one cycle after the command and leaves the active configuration unchanged. The reserved codes are: burst length 100, 101 or 110; burst length 111 with bit 3 = 1; CAS latency other than 010 or 011; bits [8:7] non-zero.
- R3: In sequential order, beat i addresses column base + ((start mod L) + i) mod L, where L is the burst length and base is the start column rounded down to a multiple of L.
- R4: In interleaved order, beat i addresses column start XOR i.
- R5: A full-page burst addresses (start + i) mod 512 and keeps going past the end of the page until it is stopped.
- R6: The beat for the edge at which its command or data is sampled is shown in the following cycle. Beat i of a command sampled at edge k is sampled at edge k+i. A write command is `cmd_op`=3. `beat_we` is high for a write beat only when `dqm` was low at that beat's own edge.
- R7: With single-access writes selected, a write produces exactly one beat, while reads still use the programmed length.
- R8: For a read command (`cmd_op`=2) sampled at edge k, the output enable for beat i is high in the cycle that ends at edge k+CL+i.
- R9: `dqm` high at edge m during a read forces `rd_oe` low for the data at edge m+2.
- R10: A burst stop (`cmd_op`=4), or a precharge (`cmd_op`=5) to the burst's bank or with `cmd_addr[10]`=1, ends the burst. No beat is issued at that edge, and a read still delivers CL-1 more enabled data cycles. A precharge to another bank with `cmd_addr[10]`=0 has no effect.
- R11: A read or write command during a burst ends that burst and starts the new one at the same edge.
- R12: `mode_busy` is high in the cycle after any mode-register-set command, so that a row activate is held off until two cycles have passed.
- R13: After reset, no beat, output enable, error or busy is shown. The configuration is burst length 1, sequential, CAS latency 2, programmed write length. `cmd_op`=0 is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Decoded command code |
| cmd_bank | input | 2 | Bank of the command |
| cmd_addr | input | 13 | Column, all-banks flag or mode word |
| dqm | input | 1 | Data mask for this cycle |
| beat_vld | output | 1 | A burst beat is presented |
| beat_we | output | 1 | Unmasked write beat |
| beat_bank | output | 2 | Bank of the beat |
| beat_col | output | 9 | Column of the beat |
| rd_oe | output | 1 | Read data output enable |
| mode_err | output | 1 | Reserved mode word rejected |
| mode_busy | output | 1 | Row activate not yet allowed |

## Verification
Some properties are checked by assertions on every cycle. A masked cycle never writes, and a stop command never lets a beat through. An enabled read output always has an unmasked mask two cycles earlier and a read beat one or two cycles earlier. A rejected mode word leaves the configuration unchanged, and a mode-register-set is always followed by the busy window. The column orderings, burst lengths, full-page wrap, CAS-dependent enable timing and the stop and restart behaviour depend on the values fed in. Only the bench's sweep can show these: it covers every legal length, order, latency and write mode, at several start columns, and compares each beat with arithmetic expectations.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MRS   = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_STOP  = 3'd4,
    OP_PRE   = 3'd5
  } op_e;

  typedef struct packed {
    logic [2:0] len_code;
    logic       ilv;
    logic       lat3;
    logic       wr_one;
  } mode_t;

  localparam mode_t MODE_RESET = '{len_code: 3'b000, ilv: 1'b0, lat3: 1'b0, wr_one: 1'b0};

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int GAP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] word,
  output mode_t             cfg,
  output logic              err,
  output logic              busy
);

  localparam int GW = $clog2(GAP + 1);

  mode_t         cfg_q, cfg_d;
  logic          err_q, err_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          ok_len, ok_lat, ok_op, legal;

  always_comb begin
    ok_len = (word[2] == 1'b0) || ((word[2:0] == 3'b111) && !word[3]);
    ok_lat = (word[6:5] == 2'b01);
    ok_op  = (word[8:7] == 2'b00);
    legal  = ok_len && ok_lat && ok_op;

    cfg_d = cfg_q;
    err_d = 1'b0;
    gap_d = gap_q;
    if (load) begin
      gap_d = GW'(GAP - 1);
      if (legal) begin
        cfg_d.len_code = word[2:0];
        cfg_d.ilv      = word[3];
        cfg_d.lat3     = word[4];
        cfg_d.wr_one   = word[9];
      end else begin
        err_d = 1'b1;
      end
    end else if (gap_q != '0) begin
      gap_d = gap_q - GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= MODE_RESET;
      err_q <= 1'b0;
      gap_q <= '0;
    end else begin
      if (load) cfg_q <= cfg_d;
      err_q <= err_d;
      gap_q <= gap_d;
    end
  end

  assign cfg  = cfg_q;
  assign err  = err_q;
  assign busy = (gap_q != '0);

  AST_MRS_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R12
  AST_RSVD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(cfg_q)); // R2
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.len_code[2] |-> (cfg_q.len_code == 3'b111 && !cfg_q.ilv)); // R1

endmodule

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen
  import sdr_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dqm,
  input  mode_t             cfg,
  output logic              beat_vld,
  output logic              beat_we,
  output logic              beat_rd,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col
);

  function automatic logic [COL_W-1:0] order_col(
    input logic [COL_W-1:0] s, input logic [COL_W-1:0] n,
    input logic [COL_W-1:0] m, input logic il);
    if (il) order_col = s ^ (n & m);
    else    order_col = (s & ~m) | ((s + n) & m);
  endfunction

  logic              act_q, act_d, wr_q, wr_d, full_q, full_d, il_q, il_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  start_q, start_d, cnt_q, cnt_d, msk_q, msk_d;
  logic              st_en;

  logic              is_rd, is_wr, new_cmd, stop_hit;
  logic [2:0]        eff_code;
  logic [COL_W-1:0]  msk_new;
  logic              full_new;

  logic              emit, emit_wr;
  logic [COL_W-1:0]  emit_col;
  logic [BANK_W-1:0] emit_bank;

  always_comb begin
    is_rd    = (op == OP_READ);
    is_wr    = (op == OP_WRITE);
    new_cmd  = is_rd || is_wr;
    stop_hit = act_q && ((op == OP_STOP) ||
               ((op == OP_PRE) && (addr[AP_BIT] || (bank == bank_q))));
    eff_code = (is_wr && cfg.wr_one) ? 3'b000 : cfg.len_code;
    full_new = (eff_code == 3'b111);
    msk_new  = full_new ? {COL_W{1'b1}}
                        : COL_W'((32'd1 << eff_code[1:0]) - 32'd1);
    st_en    = new_cmd || act_q;

    act_d = act_q;  wr_d = wr_q;  full_d = full_q;  il_d = il_q;
    bank_d = bank_q; start_d = start_q; cnt_d = cnt_q; msk_d = msk_q;
    emit = 1'b0; emit_wr = 1'b0; emit_col = '0; emit_bank = bank_q;

    if (new_cmd) begin
      act_d     = full_new || (msk_new != '0);
      wr_d      = is_wr;
      full_d    = full_new;
      il_d      = cfg.ilv;
      bank_d    = bank;
      start_d   = addr[COL_W-1:0];
      cnt_d     = COL_W'(1);
      msk_d     = msk_new;
      emit      = 1'b1;
      emit_wr   = is_wr;
      emit_col  = addr[COL_W-1:0];
      emit_bank = bank;
    end else if (stop_hit) begin
      act_d = 1'b0;
    end else if (act_q) begin
      emit     = 1'b1;
      emit_wr  = wr_q;
      emit_col = order_col(start_q, cnt_q, msk_q, il_q);
      cnt_d    = cnt_q + COL_W'(1);
      if (!full_q && (cnt_q == msk_q)) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; wr_q <= 1'b0; full_q <= 1'b0; il_q <= 1'b0;
      bank_q <= '0; start_q <= '0; cnt_q <= '0; msk_q <= '0;
    end else if (st_en) begin
      act_q <= act_d; wr_q <= wr_d; full_q <= full_d; il_q <= il_d;
      bank_q <= bank_d; start_q <= start_d; cnt_q <= cnt_d; msk_q <= msk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_vld  <= 1'b0;
      beat_we   <= 1'b0;
      beat_rd   <= 1'b0;
      beat_bank <= '0;
      beat_col  <= '0;
    end else begin
      beat_vld  <= emit;
      beat_we   <= emit && emit_wr && !dqm;
      beat_rd   <= emit && !emit_wr;
      beat_bank <= emit_bank;
      beat_col  <= emit_col;
    end
  end

  AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |=> !beat_we); // R6
  AST_STOP_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STOP) |=> !beat_vld); // R10
  AST_PAGE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && full_q && op == OP_NOP) |=> beat_vld); // R5

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3,
  parameter int SEL_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_rd,
  input  logic             dqm,
  input  logic [SEL_W-1:0] lat_sel,
  output logic             rd_oe
);

  localparam int TAPS = MAX_LAT - MIN_LAT + 1;

  logic [TAPS-1:0] tap;
  logic            dqm_q, oe_d, oe_q;

  assign tap[0] = beat_rd;

  for (genvar g = 1; g < TAPS; g++) begin : g_stage
    logic stg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= 1'b0;
      else        stg_q <= tap[g-1];
    end
    assign tap[g] = stg_q;
  end

  always_comb begin
    oe_d = tap[lat_sel] && !dqm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqm_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      dqm_q <= dqm;
      oe_q  <= oe_d;
    end
  end

  assign rd_oe = oe_q;

  AST_OE_MASK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> $past(!dqm, 2)); // R9
  AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> ($past(beat_rd, 1) || $past(beat_rd, 2))); // R8

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_seq_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = 13,
  parameter int MRS_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              dqm,
  output logic              beat_vld,
  output logic              beat_we,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              rd_oe,
  output logic              mode_err,
  output logic              mode_busy
);

  localparam int AP_BIT  = 10;
  localparam int MIN_LAT = 2;
  localparam int MAX_LAT = 3;

  mode_t cfg;
  logic  beat_rd;

  sdr_mode_reg #(.ADDR_W(ADDR_W), .GAP(MRS_GAP)) u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cmd_op == OP_MRS),
    .word (cmd_addr),
    .cfg  (cfg),
    .err  (mode_err),
    .busy (mode_busy)
  );

  sdr_burst_gen #(.COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (cmd_op),
    .bank     (cmd_bank),
    .addr     (cmd_addr),
    .dqm      (dqm),
    .cfg      (cfg),
    .beat_vld (beat_vld),
    .beat_we  (beat_we),
    .beat_rd  (beat_rd),
    .beat_bank(beat_bank),
    .beat_col (beat_col)
  );

  sdr_rd_pipe #(.MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT), .SEL_W(1)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .beat_rd(beat_rd),
    .dqm    (dqm),
    .lat_sel(cfg.lat3),
    .rd_oe  (rd_oe)
  );

endmodule

// File: tb/tb_sdr_burst_seq.sv
module tb_sdr_burst_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        dqm;
  logic        beat_vld, beat_we, rd_oe, mode_err, mode_busy;
  logic [1:0]  beat_bank;
  logic [8:0]  beat_col;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int cur_cl = 2;
  bit rb[256];
  bit dq[256];

  always #5 clk = ~clk;

  sdr_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .dqm(dqm), .beat_vld(beat_vld), .beat_we(beat_we),
    .beat_bank(beat_bank), .beat_col(beat_col), .rd_oe(rd_oe),
    .mode_err(mode_err), .mode_busy(mode_busy)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic int expcol(int s, int i, int len, int bt, bit full);
    if (full) return (s + i) % 512;
    if (bt != 0) return s ^ i;
    return (s / len) * len + ((s % len) + i) % len;
  endfunction

  task automatic tick(input int o, input int b, input int a, input bit m,
                      input bit ev, input bit ewr, input int ecol, input int ebank,
                      input string tag);
    bit ewe, eoe;
    cmd_op = 3'(o); cmd_bank = 2'(b); cmd_addr = 13'(a); dqm = m;
    ewe = ev && ewr && !m;
    dq[(cyc + 1) % 256] = m;
    rb[(cyc + 1) % 256] = ev && !ewr;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    chk(beat_vld == ev, {tag, " beat_vld"}, int'(beat_vld), int'(ev));
    if (ev) begin
      chk(beat_col == 9'(ecol), {tag, " beat_col"}, int'(beat_col), ecol);
      chk(beat_bank == 2'(ebank), {tag, " beat_bank"}, int'(beat_bank), ebank);
    end
    chk(beat_we == ewe, {tag, " beat_we"}, int'(beat_we), int'(ewe));
    eoe = rb[(cyc - cur_cl + 1 + 256) % 256] && !dq[(cyc - 1 + 256) % 256];
    chk(rd_oe == eoe, {tag, " rd_oe"}, int'(rd_oe), int'(eoe));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, tag);
  endtask

  task automatic set_mode(input int blc, input int bt, input int cl, input int wb);
    int w;
    w = (wb << 9) | (cl << 4) | (bt << 3) | blc;
    tick(1, 0, w, 1'b0, 1'b0, 1'b0, 0, 0, "R1 mrs");
    chk(mode_err == 1'b0, "R1 legal word no error", int'(mode_err), 0);
    chk(mode_busy == 1'b1, "R12 busy after mrs", int'(mode_busy), 1);
    cur_cl = cl;
    tick(0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, "R12");
    chk(mode_busy == 1'b0, "R12 busy released", int'(mode_busy), 0);
  endtask

  // stop_kind: 0 none, 1 burst stop, 2 precharge same bank, 3 precharge all banks
  task automatic burst(input bit isw, input int start, input int b, input int blc,
                       input int bt, input int wb, input int nrun, input int stop_kind,
                       input string tag);
    bit full;
    int len;
    full = (blc == 7) && !(isw && wb != 0);
    len  = (isw && wb != 0) ? 1 : (blc == 7 ? 512 : (1 << blc));
    for (int i = 0; i < nrun; i++) begin
      bit m;
      m = ((i * 3 + start) % 5) == 2;
      tick(i == 0 ? (isw ? 3 : 2) : 0, b, i == 0 ? start : 0, m,
           1'b1, isw, expcol(start, i, len, bt, full), b, tag);
    end
    if (stop_kind == 1) tick(4, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, "R10 stop");
    if (stop_kind == 2) tick(5, b, 0, 1'b0, 1'b0, 1'b0, 0, 0, "R10 pre bank");
    if (stop_kind == 3) tick(5, b ^ 1, 1 << 10, 1'b0, 1'b0, 1'b0, 0, 0, "R10 pre all");
    idle(5, {tag, " R10 drain"});
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int starts[4];
    starts = '{0, 5, 13, 510};
    rst_n = 1'b0; cmd_op = 3'd0; cmd_bank = 2'd0; cmd_addr = 13'd0; dqm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(beat_vld == 1'b0, "R13 reset beat_vld", int'(beat_vld), 0);
    chk(rd_oe == 1'b0, "R13 reset rd_oe", int'(rd_oe), 0);
    chk(mode_err == 1'b0, "R13 reset mode_err", int'(mode_err), 0);
    chk(mode_busy == 1'b0, "R13 reset mode_busy", int'(mode_busy), 0);
    idle(2, "R13");
    // default configuration: length 1, CL 2
    burst(1'b0, 37, 2, 0, 0, 0, 1, 0, "R13 default read");
    burst(1'b1, 38, 1, 0, 0, 0, 1, 0, "R13 default write");

    // near-exhaustive sweep of legal modes
    for (int cl = 2; cl <= 3; cl++)
      for (int bt = 0; bt <= 1; bt++)
        for (int k = 0; k < 5; k++)
          for (int wb = 0; wb <= 1; wb++) begin
            int blc;
            string tg;
            blc = (k == 4) ? 7 : k;
            if (blc == 7 && bt == 1) continue;
            set_mode(blc, bt, cl, wb);
            tg = (blc == 7) ? "R5" : (bt != 0 ? "R4" : "R3");
            for (int s = 0; s < 4; s++) begin
              if (blc == 7)
                burst(1'b0, starts[s], s, blc, bt, wb, 20, (s % 3) + 1,
                      $sformatf("%s/R8/R9 page read", tg));
              else
                burst(1'b0, starts[s], s, blc, bt, wb, 1 << blc, 0,
                      $sformatf("%s/R8/R9 read", tg));
              if (wb != 0)
                burst(1'b1, starts[s], s, blc, bt, wb, 1, 0, "R7/R6 single write");
              else if (blc == 7)
                burst(1'b1, starts[s], s, blc, bt, wb, 20, 1, "R5/R6 page write");
              else
                burst(1'b1, starts[s], s, blc, bt, wb, 1 << blc, 0,
                      $sformatf("%s/R6 write", tg));
            end
          end

    // early stop of a length-8 read at CL3
    set_mode(3, 0, 3, 0);
    burst(1'b0, 9, 1, 3, 0, 0, 4, 2, "R10 early stop");
    burst(1'b0, 9, 1, 3, 0, 0, 3, 1, "R10 burst stop");
    // precharge to another bank leaves the burst running
    for (int i = 0; i < 8; i++) begin
      int o, b, a;
      o = (i == 0) ? 2 : ((i == 3) ? 5 : 0);
      b = (i == 3) ? 2 : 1;
      a = (i == 0) ? 2 : 0;
      tick(o, b, a, 1'b0, 1'b1, 1'b0, expcol(2, i, 8, 0, 1'b0), 1, "R10 other bank");
    end
    idle(5, "R10 other bank drain");
    // restart by a new command mid-burst
    for (int i = 0; i < 3; i++)
      tick(i == 0 ? 2 : 0, 0, i == 0 ? 3 : 0, 1'b0, 1'b1, 1'b0,
           expcol(3, i, 8, 0, 1'b0), 0, "R11 first burst");
    for (int i = 0; i < 8; i++)
      tick(i == 0 ? 3 : 0, 1, i == 0 ? 20 : 0, 1'b0, 1'b1, 1'b1,
           expcol(20, i, 8, 0, 1'b0), 1, "R11 replacing burst");
    idle(5, "R11 drain");

    // reserved mode words are rejected
    set_mode(2, 1, 3, 0);
    begin
      int rsv[8];
      rsv = '{(3 << 4) | 4, (3 << 4) | 5, (3 << 4) | 6, (3 << 4) | 8 | 7,
              (0 << 4) | 1, (1 << 4) | 1, (4 << 4) | 1, (2 << 4) | (1 << 7) | 1};
      for (int r = 0; r < 8; r++) begin
        tick(1, 0, rsv[r], 1'b0, 1'b0, 1'b0, 0, 0, "R2 reserved");
        chk(mode_err == 1'b1, "R2 error raised", int'(mode_err), 1);
        tick(0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, "R2");
        chk(mode_err == 1'b0, "R2 error one cycle", int'(mode_err), 0);
      end
    end
    burst(1'b0, 6, 3, 2, 1, 0, 4, 0, "R2 old config kept");
    burst(1'b1, 6, 3, 2, 1, 0, 4, 0, "R2 old write length kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule